// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi and Lo Result Registers

This block takes a 32-bit multiply or divide command with two operands and works it out one bit per cycle. Multiplication is a shift-and-add loop and division is restoring division. Either operation can treat its operands as unsigned or as two's complement. The unit keeps its answer in two result registers, Hi and Lo. A product fills both: its upper word goes to Hi and its lower word to Lo. A division puts its quotient in Lo and its remainder in Hi. A separate read port copies either register out, the way a move-from instruction would.

Commands arrive on a valid/ready channel. `start_ready` is high only while the unit is idle. A command is taken on a clock edge where `start_valid` and `start_ready` are both high. A command offered while the unit computes is not queued; it is dropped. The read port also uses a handshake. `rd_ready` is low while a computation is running, so a reader has to hold `rd_valid` until the unit is idle. Hi and Lo keep their values until the next command finishes.

Top module: `mdu_top`

## Requirements
- R1: With `start_op`=0 (multiply) and `start_signed`=0, Hi holds bits 63..32 and Lo holds bits 31..0 of the unsigned 64-bit product.
- R2: With `start_op`=0 and `start_signed`=1, Hi:Lo holds the 64-bit two's-complement product of the operands.
- R3: With `start_op`=1 (divide), `start_signed`=0 and a nonzero divisor, Lo holds the unsigned quotient and Hi holds the remainder.
- R4: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. Dividing the most negative value by -1 gives Lo = 0x80000000 and Hi = 0.
- R5: A divide by zero finishes with the same latency as any other command. It writes all ones to Lo and the unmodified dividend to Hi. It raises `div_zero`, which stays high until the next command is accepted.
- R6: `busy` goes high in the cycle after a command is accepted and stays high for exactly 33 cycles. New results are readable in the first cycle where `busy` is low again. `start_ready` equals the inverse of `busy`.
- R7: A command offered while `busy` is high is not accepted. It has no effect on the results of the command in progress or on later results.
- R8: `rd_ready` is low while `busy` is high. During a read handshake, `rd_data` shows Hi when `rd_sel`=1 and Lo when `rd_sel`=0. Outside a handshake it is zero.
- R9: Hi and Lo hold their values between commands. A read made in the same cycle that a new command is accepted returns the results of the previous command.
- R10: After reset, `busy` and `div_zero` are low, `start_ready` is high, and both Hi and Lo read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Unit can take a command (idle) |
| start_op | input | 1 | 0 = multiply, 1 = divide |
| start_signed | input | 1 | 1 = operands are two's complement |
| start_a | input | 32 | Multiplicand or dividend |
| start_b | input | 32 | Multiplier or divisor |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read can complete (idle) |
| rd_sel | input | 1 | 1 = read Hi, 0 = read Lo |
| rd_data | output | 32 | Read data during a read handshake |
| busy | output | 1 | Computation in progress |
| div_zero | output | 1 | Last finished command divided by zero |

## Verification
Two functions can fall in the same cycle: a reader collecting the results of one command, and the acceptance of the next command. The bench provokes this by issuing commands back to back. The driver offers each new command on the first idle cycle. In that same cycle the monitor reads Hi and Lo for the command that just finished and checks them against its scoreboard. Any leak of the new command into those reads shows up as a mismatch. A timing mismatch of this kind would also break the 33-cycle busy count that is checked for every command.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    MDU_MUL = 1'b0,
    MDU_DIV = 1'b1
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdu_state_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic step_en,
  output logic fin
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mdu_state_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) st_q <= ST_FIN;
          cnt_q <= cnt_q + 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign step_en = (st_q == ST_RUN);
  assign fin     = (st_q == ST_FIN);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (cnt_q <= LAST)); // R6
  AST_RUN_ENDS_IN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cnt_q == LAST) |=> (st_q == ST_FIN)); // R6
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == ST_IDLE)); // R7
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] p_q;
  logic [W:0]     sum;

  always_comb begin
    sum = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mcand_q} : {(W+1){1'b0}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      p_q     <= '0;
    end else if (load) begin
      mcand_q <= mcand_i;
      p_q     <= {{W{1'b0}}, mplier_i};
    end else if (step) begin
      p_q <= {sum, p_q[W-1:1]};
    end
  end

  assign prod_o = p_q;

  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(mcand_q)); // R1
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] dvs_q, rem_q, quo_q;
  logic         act_q;
  logic [W:0]   shifted, trial;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = (shifted >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      dvs_q <= dvs_i;
      rem_q <= '0;
      quo_q <= dvd_i;
      act_q <= 1'b1;
    end else if (step) begin
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && dvs_q != '0) |-> (rem_q < dvs_q)); // R3
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic         start_op,
  input  logic         start_signed,
  input  logic [W-1:0] start_a,
  input  logic [W-1:0] start_b,
  input  logic         rd_valid,
  output logic         rd_ready,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         div_zero
);
  logic go, step_en, fin;
  logic [W-1:0] mag_a, mag_b;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0] quo, rem, quo_fix, rem_fix;

  mdu_op_e      op_q;
  logic         neg_prod_q, neg_quo_q, neg_rem_q, dz_q, dz_flag_q;
  logic [W-1:0] a_q, hi_q, lo_q;

  assign start_ready = !busy;
  assign go          = start_valid && start_ready;

  always_comb begin
    mag_a = (start_signed && start_a[W-1]) ? (~start_a + 1'b1) : start_a;
    mag_b = (start_signed && start_b[W-1]) ? (~start_b + 1'b1) : start_b;
  end

  mdu_seq #(.STEPS(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go),
    .busy(busy), .step_en(step_en), .fin(fin)
  );

  mdu_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(go), .step(step_en && op_q == MDU_MUL),
    .mcand_i(mag_a), .mplier_i(mag_b), .prod_o(prod)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(go), .step(step_en && op_q == MDU_DIV),
    .dvd_i(mag_a), .dvs_i(mag_b), .quo_o(quo), .rem_o(rem)
  );

  always_comb begin
    prod_fix = neg_prod_q ? (~prod + 1'b1) : prod;
    quo_fix  = neg_quo_q  ? (~quo + 1'b1)  : quo;
    rem_fix  = neg_rem_q  ? (~rem + 1'b1)  : rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q       <= MDU_MUL;
      neg_prod_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      dz_q       <= 1'b0;
      dz_flag_q  <= 1'b0;
      a_q        <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else if (go) begin
      op_q       <= mdu_op_e'(start_op);
      neg_prod_q <= start_signed && (start_a[W-1] ^ start_b[W-1]);
      neg_quo_q  <= start_signed && (start_a[W-1] ^ start_b[W-1]);
      neg_rem_q  <= start_signed && start_a[W-1];
      dz_q       <= start_op && (start_b == '0);
      dz_flag_q  <= 1'b0;
      a_q        <= start_a;
    end else if (fin) begin
      if (op_q == MDU_MUL) begin
        hi_q <= prod_fix[2*W-1:W];
        lo_q <= prod_fix[W-1:0];
      end else if (dz_q) begin
        hi_q      <= a_q;
        lo_q      <= '1;
        dz_flag_q <= 1'b1;
      end else begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end
    end
  end

  assign div_zero = dz_flag_q;
  assign rd_ready = !busy;
  assign rd_data  = (rd_valid && rd_ready) ? (rd_sel ? hi_q : lo_q) : '0;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R6
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(hi_q) && $stable(lo_q))); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> ($stable(a_q) && $stable(op_q))); // R7
  AST_DZ_FROM_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dz_flag_q) |-> ($past(fin) && $past(op_q == MDU_DIV))); // R5
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data == '0)); // R8
endmodule

// File: tb/mdu_top_tb.sv
module mdu_top_tb_top;
  localparam int W = 32;
  localparam int LAT = W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, start_op = 1'b0, start_signed = 1'b0;
  logic [W-1:0] start_a = '0, start_b = '0;
  logic rd_valid = 1'b0, rd_sel = 1'b0;
  logic start_ready, rd_ready, busy, div_zero;
  logic [W-1:0] rd_data;

  int n_run = 0, n_fail = 0, n_issued = 0, n_done = 0;
  logic [2*W:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mdu_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_op(start_op), .start_signed(start_signed), .start_a(start_a), .start_b(start_b),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy), .div_zero(div_zero)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2*W:0] model(input logic op, input logic sg,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] p;
    logic [W-1:0] q, r;
    if (!op) begin
      if (sg) p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
      else    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      return {1'b0, p};
    end
    if (b == '0) return {1'b1, a, {W{1'b1}}};
    if (sg && a == {1'b1, {(W-1){1'b0}}} && b == '1) return {1'b0, {W{1'b0}}, a};
    if (sg) begin
      q = $signed(a) / $signed(b);
      r = $signed(a) % $signed(b);
    end else begin
      q = a / b;
      r = a % b;
    end
    return {1'b0, r, q};
  endfunction

  task automatic issue(input logic op, input logic sg, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string tag);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1; start_op = op; start_signed = sg; start_a = a; start_b = b;
    exp_q.push_back(model(op, sg, a, b));
    tag_q.push_back(tag);
    n_issued++;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic poke_while_busy();
    for (int i = 0; i < 3; i++) begin
      start_valid = 1'b1; start_op = 1'b1; start_signed = 1'b1;
      start_a = 32'hDEAD_BEEF; start_b = 32'h0;
      check("R7 start_ready low while busy", {63'd0, start_ready}, 64'd0);
      @(negedge clk);
    end
    start_valid = 1'b0;
  endtask

  // monitor: latency count and scoreboard compare at the first idle cycle
  initial begin
    int bcnt = 0;
    logic prev_busy = 1'b0;
    logic [2*W:0] e;
    string t;
    logic [W-1:0] gh, gl;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (busy) begin
        bcnt++;
        if (bcnt == 5) begin
          check("R8 rd_ready low while busy", {63'd0, rd_ready}, 64'd0);
          check("R8 rd_data zero while busy", {32'd0, rd_data}, 64'd0);
        end
      end else if (prev_busy) begin
        check("R6 busy length", 64'(bcnt), 64'(LAT));
        rd_valid = 1'b1; rd_sel = 1'b1; #1;
        gh = rd_data; rd_sel = 1'b0; #1;
        gl = rd_data; rd_valid = 1'b0;
        check("R8 rd_ready when idle", {63'd0, rd_ready}, 64'd1);
        if (exp_q.size() == 0) begin
          check("R7 unexpected completion", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({t, " Hi:Lo"}, {gh, gl}, e[2*W-1:0]);
          check({t, " R5 div_zero"}, {63'd0, div_zero}, {63'd0, e[2*W]});
        end
        n_done++;
        bcnt = 0;
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", {63'd0, busy}, 64'd0);
    check("R10 start_ready", {63'd0, start_ready}, 64'd1);
    check("R10 div_zero", {63'd0, div_zero}, 64'd0);
    rd_valid = 1'b1; rd_sel = 1'b1; #1;
    check("R10 Hi", {32'd0, rd_data}, 64'd0);
    rd_sel = 1'b0; #1;
    check("R10 Lo", {32'd0, rd_data}, 64'd0);
    rd_valid = 1'b0;

    issue(1'b0, 1'b0, 32'd3, 32'd5, "R1 small");
    issue(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 max");
    issue(1'b0, 1'b1, -32'sd3, 32'd7, "R2 neg*pos");
    issue(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    issue(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    poke_while_busy();
    issue(1'b1, 1'b0, 32'd100, 32'd7, "R3 100/7");
    issue(1'b1, 1'b0, 32'hFFFF_FFFF, 32'd3, "R3 max/3");
    issue(1'b1, 1'b0, 32'd5, 32'd9, "R3 small dividend");
    issue(1'b1, 1'b1, -32'sd7, 32'd2, "R4 -7/2");
    issue(1'b1, 1'b1, 32'd7, -32'sd2, "R4 7/-2");
    poke_while_busy();
    issue(1'b1, 1'b1, -32'sd7, -32'sd2, "R4 -7/-2");
    issue(1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    issue(1'b1, 1'b0, 32'd5, 32'd0, "R5 unsigned by zero");
    issue(1'b1, 1'b1, -32'sd9, 32'd0, "R5 signed by zero");
    issue(1'b0, 1'b0, 32'd2, 32'd2, "R5 flag cleared by mul");
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = (i % 4 == 3) ? ($urandom & 32'hFF) : $urandom;
      issue(1'(i % 2), 1'((i / 2) % 2), a, b, "R9 back-to-back random");
    end
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    rd_valid = 1'b1; rd_sel = 1'b0; #1;
    begin
      logic [W-1:0] keep_lo;
      keep_lo = rd_data;
      rd_valid = 1'b0;
      repeat (4) @(negedge clk);
      rd_valid = 1'b1; #1;
      check("R9 Lo held while idle", {32'd0, rd_data}, {32'd0, keep_lo});
      rd_valid = 1'b0;
    end
    check("R7 completions match accepted", 64'(n_done), 64'(n_issued));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule